// File: doc/BRIEF.md
# H-Bridge Switch Decode

This block turns the control inputs of a full-bridge motor driver into the four switch enables of the bridge. It takes the high-side and low-side switch of leg A and of leg B. The inputs are a direction bit, a drive enable, a decay select, an awake input (low means sleep), a zero-current flag, four fault flags and two flags from an internal chopping controller. The two chopping flags say that a fixed off time is running and whether that off time is in its fast-decay part.

While drive is active, the block closes the high-side switch of one leg and the low-side switch of the other, as the direction bit selects. While the bridge is decaying, it picks the recirculation path. Fast decay turns on the opposite diagonal. Slow decay turns on both low-side switches, which also brakes the motor. If zero load current is seen during decay, every switch opens so that the current cannot reverse. The switches stay open until drive resumes. Any fault or sleep opens all four switches.

Every output is registered. A dead-time guard on each leg keeps the two switches of a leg from ever being closed together. It also holds a leg fully open for a set number of clocks before either of its switches may close.

Top module: `hbridge_switch_decode`

## Requirements
- R1: Drive is active when drive_en_i=1 and chop_off_i=0. With dir_i=1 the target is hs_a and ls_b. With dir_i=0 the target is hs_b and ls_a. Outputs follow the target one clock after the inputs are sampled, subject to R10.
- R2: When drive_en_i=0 and slow_decay_i=0, the target is the diagonal opposite the one dir_i selects for drive (fast decay).
- R3: When drive_en_i=0 and slow_decay_i=1, the target is ls_a and ls_b with both high sides open (slow decay and brake).
- R4: When drive_en_i=1 and chop_off_i=1, the internal off time is running. If chop_fast_i=1 the target is the opposite diagonal. If chop_fast_i=0 the target is both low sides.
- R5: If zero_cur_i=1 in any non-drive cycle, the target of that cycle and of every later non-drive cycle is all four switches open. This holds even after zero_cur_i falls, and ends only when drive becomes active again.
- R6: zero_cur_i has no effect in a drive cycle. It neither opens the drive pair nor arms the cutoff of R5.
- R7: If any of flt_therm_i, flt_pump_i, flt_reg_i or flt_uvlo_i is 1, all four outputs are 0 one clock later. This lasts for as long as the fault is present.
- R8: If awake_i=0 (sleep), all four outputs are 0 one clock later.
- R9: hs_a_o and ls_a_o are never 1 together. hs_b_o and ls_b_o are never 1 together.
- R10: A switch may close only after its leg has had both outputs at 0 for at least DEAD_CYC consecutive clocks. A switch whose target drops opens at the next clock.
- R11: While rst_ni=0, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Direction select |
| drive_en_i | input | 1 | External drive enable; 0 chops |
| slow_decay_i | input | 1 | External decay select: 1 slow, 0 fast |
| awake_i | input | 1 | 0 puts the block in sleep |
| zero_cur_i | input | 1 | Zero load current detected |
| flt_therm_i | input | 1 | Over-temperature fault |
| flt_pump_i | input | 1 | Charge-pump low fault |
| flt_reg_i | input | 1 | Regulator low fault |
| flt_uvlo_i | input | 1 | Logic-supply undervoltage |
| chop_off_i | input | 1 | Internal fixed off time running |
| chop_fast_i | input | 1 | Off time is in its fast-decay part |
| hs_a_o | output | 1 | Leg A high-side switch enable |
| ls_a_o | output | 1 | Leg A low-side switch enable |
| hs_b_o | output | 1 | Leg B high-side switch enable |
| ls_b_o | output | 1 | Leg B low-side switch enable |

## Verification
The bench first sweeps all 2048 combinations of the eleven control inputs, holding each for a few clocks. This tells apart the drive diagonals, the two decay paths and the masking by faults and sleep. Directed sequences then reverse direction and toggle between drive and decay. These show that every leg handover passes through the dead-time gap, and that a switch which is dropped opens at the next clock. Zero-current pulses are applied in decay and then removed before drive resumes. This separates a sticky cutoff from one that only follows the flag, and the same pulses in drive confirm that the flag is ignored there. A long random run with rare faults then mixes all of these effects. It is compared every clock against a behavioural model that predicts the outputs.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned LEG_A    = 0;
  localparam int unsigned LEG_B    = 1;

  typedef struct packed {
    logic hs;
    logic ls;
  } leg_sw_t;

  typedef leg_sw_t [NUM_LEGS-1:0] bridge_sw_t;
endpackage

// File: rtl/hbd_zc_latch.sv
module hbd_zc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_i,
  input  logic zero_cur_i,
  output logic cut_o
);
  logic zc_q;

  // arms on zero current outside drive, disarms when drive resumes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        zc_q <= 1'b0;
    else if (drive_i)   zc_q <= 1'b0;
    else if (zero_cur_i) zc_q <= 1'b1;
  end

  assign cut_o = !drive_i && (zero_cur_i || zc_q);

  assert_zc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zc_q && !drive_i) |=> zc_q);

  assert_zc_ignore_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |=> !zc_q);
endmodule

// File: rtl/hbd_target.sv
module hbd_target
  import hbd_pkg::*;
(
  input  logic       ok_i,
  input  logic       drive_i,
  input  logic       dir_i,
  input  logic       drive_en_i,
  input  logic       slow_decay_i,
  input  logic       chop_fast_i,
  input  logic       cut_i,
  output bridge_sw_t tgt_o
);
  logic fast;
  logic decay_on;

  always_comb begin
    // external chop uses the decay select; internal off time uses its own phase flag
    fast     = drive_en_i ? chop_fast_i : !slow_decay_i;
    decay_on = ok_i && !drive_i && !cut_i;
    tgt_o    = '0;
    if (ok_i && drive_i) begin
      tgt_o[LEG_A].hs = dir_i;
      tgt_o[LEG_A].ls = !dir_i;
      tgt_o[LEG_B].hs = !dir_i;
      tgt_o[LEG_B].ls = dir_i;
    end else if (decay_on) begin
      if (fast) begin
        tgt_o[LEG_A].hs = !dir_i;
        tgt_o[LEG_A].ls = dir_i;
        tgt_o[LEG_B].hs = dir_i;
        tgt_o[LEG_B].ls = !dir_i;
      end else begin
        tgt_o[LEG_A].ls = 1'b1;
        tgt_o[LEG_B].ls = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LEGS; i++) begin
      assert_tgt_one_side_R9: assert (!(tgt_o[i].hs && tgt_o[i].ls));
    end
  end
endmodule

// File: rtl/hbd_leg_guard.sv
module hbd_leg_guard
  import hbd_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  leg_sw_t tgt_i,
  output leg_sw_t sw_o
);
  localparam int unsigned CNT_W = $clog2(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEAD_CYC);
  localparam logic [CNT_W-1:0] CNT_GO  = CNT_W'(DEAD_CYC - 1);

  leg_sw_t         sw_q, sw_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sw_d  = '0;
    cnt_d = cnt_q;
    if (sw_q.hs) begin
      sw_d.hs = tgt_i.hs;
      cnt_d   = '0;
    end else if (sw_q.ls) begin
      sw_d.ls = tgt_i.ls;
      cnt_d   = '0;
    end else begin
      if (cnt_q >= CNT_GO) sw_d = tgt_i;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      cnt_q <= '0;
    end else begin
      sw_q  <= sw_d;
      cnt_q <= cnt_d;
    end
  end

  assign sw_o = sw_q;

  // independent off-run count for the dead-time check
  int unsigned chk_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 chk_run <= 0;
    else if (sw_q.hs || sw_q.ls) chk_run <= 0;
    else if (chk_run < DEAD_CYC) chk_run <= chk_run + 1;
  end

  assert_no_shoot_through_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_q.hs && sw_q.ls));

  assert_dead_time_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sw_q.hs) || $rose(sw_q.ls)) |-> (chk_run >= DEAD_CYC));

  assert_fast_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q.hs && !tgt_i.hs) |=> !sw_q.hs);
endmodule

// File: rtl/hbridge_switch_decode.sv
module hbridge_switch_decode
  import hbd_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic drive_en_i,
  input  logic slow_decay_i,
  input  logic awake_i,
  input  logic zero_cur_i,
  input  logic flt_therm_i,
  input  logic flt_pump_i,
  input  logic flt_reg_i,
  input  logic flt_uvlo_i,
  input  logic chop_off_i,
  input  logic chop_fast_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o
);
  logic       flt_any, ok, drive, cut;
  bridge_sw_t tgt, sw;

  assign flt_any = flt_therm_i || flt_pump_i || flt_reg_i || flt_uvlo_i;
  assign ok      = awake_i && !flt_any;
  assign drive   = drive_en_i && !chop_off_i;

  hbd_zc_latch u_zc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drive_i    (drive),
    .zero_cur_i (zero_cur_i),
    .cut_o      (cut)
  );

  hbd_target u_tgt (
    .ok_i         (ok),
    .drive_i      (drive),
    .dir_i        (dir_i),
    .drive_en_i   (drive_en_i),
    .slow_decay_i (slow_decay_i),
    .chop_fast_i  (chop_fast_i),
    .cut_i        (cut),
    .tgt_o        (tgt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbd_leg_guard #(.DEAD_CYC(DEAD_CYC)) u_guard (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tgt_i  (tgt[g]),
      .sw_o   (sw[g])
    );
  end

  assign hs_a_o = sw[LEG_A].hs;
  assign ls_a_o = sw[LEG_A].ls;
  assign hs_b_o = sw[LEG_B].hs;
  assign ls_b_o = sw[LEG_B].ls;

  assert_fault_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_any |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

  assert_sleep_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_i |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

  assert_cut_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive && zero_cur_i) |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));
endmodule

// File: tb/hbridge_switch_decode_tb_top.sv
module hbridge_switch_decode_tb_top;
  localparam int DEAD = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dir_i = 0, drive_en_i = 0, slow_decay_i = 0, awake_i = 0, zero_cur_i = 0;
  logic flt_therm_i = 0, flt_pump_i = 0, flt_reg_i = 0, flt_uvlo_i = 0;
  logic chop_off_i = 0, chop_fast_i = 0;
  logic hs_a_o, ls_a_o, hs_b_o, ls_b_o;

  always #4 clk_i = ~clk_i;

  hbridge_switch_decode #(.DEAD_CYC(DEAD)) dut_i (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_hs[2], m_ls[2];
  int m_run[2];
  bit m_zc;
  string m_tag = "R11";

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input bit act, input bit exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(m_tag, hs_a_o, m_hs[0], "hs_a");
    chk(m_tag, ls_a_o, m_ls[0], "ls_a");
    chk(m_tag, hs_b_o, m_hs[1], "hs_b");
    chk(m_tag, ls_b_o, m_ls[1], "ls_b");
    chk("R9", hs_a_o & ls_a_o, 1'b0, "leg A both on");
    chk("R9", hs_b_o & ls_b_o, 1'b0, "leg B both on");
  endtask

  task automatic model_next();
    bit ok, drv, fast, cut;
    bit th[2], tl[2];
    ok   = awake_i && !(flt_therm_i || flt_pump_i || flt_reg_i || flt_uvlo_i);
    drv  = drive_en_i && !chop_off_i;
    fast = drive_en_i ? chop_fast_i : !slow_decay_i;
    cut  = !drv && (zero_cur_i || m_zc);
    if (!awake_i) m_tag = "R8";
    else if (!ok) m_tag = "R7";
    else if (drv) m_tag = zero_cur_i ? "R6" : "R1";
    else if (cut) m_tag = "R5";
    else if (drive_en_i) m_tag = "R4";
    else m_tag = slow_decay_i ? "R3" : "R2";
    th = '{0, 0}; tl = '{0, 0};
    if (ok && drv) begin
      th[0] = dir_i; tl[1] = dir_i; th[1] = !dir_i; tl[0] = !dir_i;
    end else if (ok && !cut) begin
      if (fast) begin
        th[1] = dir_i; tl[0] = dir_i; th[0] = !dir_i; tl[1] = !dir_i;
      end else begin
        tl[0] = 1; tl[1] = 1;
      end
    end
    m_zc = drv ? 1'b0 : (m_zc | zero_cur_i);
    for (int l = 0; l < 2; l++) begin
      if (m_hs[l]) begin
        m_hs[l] = th[l]; m_ls[l] = 0;
      end else if (m_ls[l]) begin
        m_ls[l] = tl[l]; m_hs[l] = 0;
      end else if (m_run[l] >= DEAD) begin
        m_hs[l] = th[l]; m_ls[l] = tl[l];
      end
      // R10: count consecutive all-off cycles of the new state
      if (m_hs[l] || m_ls[l]) m_run[l] = 0;
      else if (m_run[l] < DEAD) m_run[l] = m_run[l] + 1;
    end
  endtask

  task automatic cycle(input logic [10:0] v);
    @(negedge clk_i);
    compare();
    {chop_fast_i, chop_off_i, flt_uvlo_i, flt_reg_i, flt_pump_i, flt_therm_i,
     zero_cur_i, awake_i, slow_decay_i, drive_en_i, dir_i} = v;
    model_next();
  endtask

  task automatic hold(input logic [10:0] v, input int n);
    for (int i = 0; i < n; i++) cycle(v);
  endtask

  // vector bits: [0]dir [1]en [2]slow [3]awake [4]zc [8:5]faults [9]chop_off [10]chop_fast
  localparam logic [10:0] FWD   = 11'b000_0000_1011;
  localparam logic [10:0] REV   = 11'b000_0000_1010;
  localparam logic [10:0] FDEC  = 11'b000_0000_1001;
  localparam logic [10:0] BRAKE = 11'b000_0000_1101;

  initial begin
    m_hs = '{0, 0}; m_ls = '{0, 0}; m_run = '{1, 1}; m_zc = 0;
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk("R11", hs_a_o | ls_a_o | hs_b_o | ls_b_o, 1'b0, "outputs in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    {chop_fast_i, chop_off_i, flt_uvlo_i, flt_reg_i, flt_pump_i, flt_therm_i,
     zero_cur_i, awake_i, slow_decay_i, drive_en_i, dir_i} = FWD;
    model_next();
    hold(FWD, 6);                       // R1 forward drive
    hold(REV, 6);                       // R1 reversal through dead time R10
    hold(FDEC, 6);                      // R2 fast decay
    hold(BRAKE, 6);                     // R3 brake
    hold(FWD | 11'h200, 6);             // R4 internal off, slow part
    hold(FWD | 11'h600, 6);             // R4 internal off, fast part
    hold(FWD | 11'h010, 6);             // R6 zero current ignored in drive
    hold(FDEC | 11'h010, 2);            // R5 cutoff
    hold(FDEC, 5);                      // R5 cutoff sticks
    hold(FWD, 6);                       // R5 released by drive
    hold(FWD | 11'h020, 4);             // R7 thermal
    hold(FWD, 5);
    hold(FWD | 11'h100, 4);             // R7 undervoltage
    hold(FWD & ~11'h008, 4);            // R8 sleep
    hold(FWD, 5);
    for (int v = 0; v < 2048; v++) hold(11'(v), 3);
    for (int i = 0; i < 40000; i++) begin
      logic [10:0] r;
      r = 11'($urandom);
      r[3] = ($urandom % 16) != 0;
      r[8:5] = {($urandom % 32) == 0, ($urandom % 32) == 0,
                ($urandom % 32) == 0, ($urandom % 32) == 0};
      r[4] = ($urandom % 8) == 0;
      hold(r, 1 + ($urandom % 4));
    end
    @(negedge clk_i);
    compare();
    report();
  end

  initial begin
    #1600000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end
endmodule